// File: doc/BRIEF.md
# Low-Power Clock Source Controller

This block sits beside a microcontroller's clock generator and decides, from run, wait and stop requests, which oscillator sources stay powered and which source feeds the bus clock. The bus clock is half the frequency of the source picked by a software-controlled source-select bit: either the crystal clock or the VCO clock. A PLL-on bit powers the PLL. A keep-oscillator bit decides whether the crystal oscillator keeps running during stop. The block drives the oscillator and PLL enables, a gated copy of the crystal clock, the bus clock and a gated lock interrupt.

The sequencing runs in the crystal clock domain. A stop request moves the block into stop and clears the source-select bit in hardware, so the chip always restarts from crystal/2. Wait leaves every clock running. Waking from a stop in which the oscillator was powered down first spends a fixed start-up count of crystal cycles with all outputs quiet. Switching between the two sources is handed over between two gated divider branches, one in each source domain, so the bus clock never carries a runt pulse.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset the select, PLL-on and keep-oscillator bits read 0, the mode is run, osc_en is 1, pll_en is 0 and bus_clk runs at crystal/2.
- R2: In run or wait, bus_clk runs at the VCO clock divided by two when the select bit is 1, and at the crystal clock divided by two when it is 0.
- R3: A register write is accepted only in run or wait. It loads the PLL-on and keep-oscillator bits from the written values. The select bit loads the written select value ANDed with the written PLL-on value, so a write that asks for the VCO with PLL-on at 0 leaves the select bit at 0. Writes in stop or start-up change nothing.
- R4: Every high phase and every low phase of bus_clk, including across a source change, lasts at least one period of the faster source clock, and at most one divider branch drives it at a time.
- R5: Wait, entered by wait_req in run, keeps osc_en, pll_en, the crystal output and the bus clock exactly as in run. A wake in wait returns to run.
- R6: In stop with the keep-oscillator bit at 0: osc_en, pll_en, irq_out, xclk_out and bus_clk are all 0.
- R7: In stop with the keep-oscillator bit at 1: osc_en stays 1 and xclk_out keeps toggling at the crystal rate, while pll_en, irq_out and bus_clk are 0.
- R8: The crystal cycle that enters stop also clears the select bit. After waking, the select bit reads 0 and bus_clk runs at crystal/2 until software writes it again.
- R9: A wake in stop with the keep-oscillator bit at 0 enters a start-up phase of STARTUP_CYC (default 16) crystal cycles. During that phase osc_en is 1 and pll_en, irq_out, xclk_out and bus_clk are 0, and the block then returns to run. With the keep-oscillator bit at 1, a wake returns to run on the next crystal edge.
- R10: irq_out equals lock_irq_req in run and wait, and is 0 in stop and start-up.
- R11: In run, stop_req takes priority over wait_req when both are high. stop_req is ignored in wait, and wake is ignored in run.
- R12: In run and wait, pll_en equals the PLL-on bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock; also clocks the mode sequencer |
| clk_vco | input | 1 | VCO clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | Request to enter wait (sampled in run) |
| stop_req | input | 1 | Request to enter stop (sampled in run) |
| wake | input | 1 | Wake event for wait or stop |
| reg_we | input | 1 | Register write strobe |
| reg_sel_vco | input | 1 | Written value of the source-select bit |
| reg_pll_on | input | 1 | Written value of the PLL-on bit |
| reg_osc_keep | input | 1 | Written value of the keep-oscillator-in-stop bit |
| lock_irq_req | input | 1 | Interrupt request from the PLL lock logic |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| irq_out | output | 1 | Gated interrupt output |
| xclk_out | output | 1 | Gated crystal clock |
| bus_clk | output | 1 | Selected source divided by two |
| sel_vco_o | output | 1 | Readback of the source-select bit |
| pll_on_o | output | 1 | Readback of the PLL-on bit |
| osc_keep_o | output | 1 | Readback of the keep-oscillator bit |

## Verification
The bench requests the VCO while PLL-on is 0. A design that lets that write through would read back a set select bit and clock the bus from a stopped VCO. It enters stop while the VCO drives the bus, then checks that the select bit reads 0 and that the bus restarts at crystal/2 instead of switching straight back to the VCO. It watches every bus-clock phase across source changes in both directions to catch the runt pulse or overlap that a plain multiplexer would produce. It compares the start-up phase cycle by cycle against the model, so a counter that is off by one releases pll_en and irq_out on the wrong edge, and it checks that the start-up wait is skipped when the oscillator was kept running.

// File: rtl/lpclk_pkg.sv
`timescale 1ns/1ps
package lpclk_pkg;
   typedef enum logic [1:0] {
      M_RUN   = 2'd0,
      M_WAIT  = 2'd1,
      M_STOP  = 2'd2,
      M_START = 2'd3
   } lp_mode_e;

   localparam int NUM_SRC  = 2;
   localparam int SRC_XTAL = 0;
   localparam int SRC_VCO  = 1;
endpackage

// File: rtl/lpclk_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer into the domain of clk.
module lpclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_a,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_a};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/lpclk_branch.sv
`timescale 1ns/1ps
// One source branch: divide-by-two of clk_src, enabled only when this
// source is wanted and the peer branch reports idle. The divider starts
// and stops only from its low phase, so the output carries no short pulse.
module lpclk_branch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_src,
   input  logic rst_n,
   input  logic want_a,
   input  logic peer_busy_a,
   output logic clk_gated,
   output logic busy
);
   logic want_s, peer_s, en_q, div_q, busy_q;

   lpclk_sync #(.STAGES(SYNC_STAGES)) u_sync_want (
      .clk(clk_src), .rst_n(rst_n), .d_a(want_a), .q(want_s)
   );
   lpclk_sync #(.STAGES(SYNC_STAGES)) u_sync_peer (
      .clk(clk_src), .rst_n(rst_n), .d_a(peer_busy_a), .q(peer_s)
   );

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         div_q  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         en_q   <= want_s & ~peer_s;
         div_q  <= div_q ? 1'b0 : en_q;
         busy_q <= en_q | div_q;
      end
   end

   assign clk_gated = div_q;
   assign busy      = busy_q;
endmodule

// File: rtl/lpclk_seq.sv
`timescale 1ns/1ps
// Mode sequencer and configuration bits, crystal domain.
module lpclk_seq
   import lpclk_pkg::*;
#(
   parameter int STARTUP_CYC = 16,
   parameter int CNT_W       = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wait_req,
   input  logic               stop_req,
   input  logic               wake,
   input  logic               reg_we,
   input  logic               wr_sel,
   input  logic               wr_pll,
   input  logic               wr_keep,
   output lp_mode_e           mode_q,
   output logic [CNT_W-1:0]   cnt_q,
   output logic               sel_q,
   output logic               pll_q,
   output logic               keep_q,
   output logic               osc_en,
   output logic               pll_en,
   output logic               active,
   output logic               xclk_en,
   output logic [NUM_SRC-1:0] want
);
   lp_mode_e mode_d, wake_tgt;
   logic     start_done, cfg_wr_ok, enter_stop, in_stop;

   if (STARTUP_CYC > 0) begin : g_start
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYC - 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt_q <= '0;
         else if (mode_q != M_START) cnt_q <= '0;
         else                        cnt_q <= cnt_q + 1'b1;
      end
      assign start_done = (cnt_q == LAST);
      assign wake_tgt   = keep_q ? M_RUN : M_START;
   end else begin : g_nostart
      assign cnt_q      = '0;
      assign start_done = 1'b1;
      assign wake_tgt   = M_RUN;
   end

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         M_RUN:   if (stop_req) mode_d = M_STOP;
                  else if (wait_req) mode_d = M_WAIT;
         M_WAIT:  if (wake) mode_d = M_RUN;
         M_STOP:  if (wake) mode_d = wake_tgt;
         M_START: if (start_done) mode_d = M_RUN;
         default: mode_d = M_RUN;
      endcase
   end

   assign active     = (mode_q == M_RUN) || (mode_q == M_WAIT);
   assign in_stop    = (mode_q == M_STOP);
   assign cfg_wr_ok  = reg_we && active;
   assign enter_stop = (mode_d == M_STOP) && !in_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_RUN;
         sel_q  <= 1'b0;
         pll_q  <= 1'b0;
         keep_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (cfg_wr_ok) begin
            pll_q  <= wr_pll;
            keep_q <= wr_keep;
         end
         if (enter_stop)     sel_q <= 1'b0;
         else if (cfg_wr_ok) sel_q <= wr_sel & wr_pll;
      end
   end

   assign osc_en         = !(in_stop && !keep_q);
   assign pll_en         = pll_q && active;
   assign xclk_en        = active || (in_stop && keep_q);
   assign want[SRC_XTAL] = active && !sel_q;
   assign want[SRC_VCO]  = active && sel_q;
endmodule

// File: rtl/lpclk_ctrl.sv
`timescale 1ns/1ps
module lpclk_ctrl
   import lpclk_pkg::*;
#(
   parameter int STARTUP_CYC = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_xtal,
   input  logic clk_vco,
   input  logic rst_n,
   input  logic wait_req,
   input  logic stop_req,
   input  logic wake,
   input  logic reg_we,
   input  logic reg_sel_vco,
   input  logic reg_pll_on,
   input  logic reg_osc_keep,
   input  logic lock_irq_req,
   output logic osc_en,
   output logic pll_en,
   output logic irq_out,
   output logic xclk_out,
   output logic bus_clk,
   output logic sel_vco_o,
   output logic pll_on_o,
   output logic osc_keep_o
);
   localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lpclk_ctrl: SYNC_STAGES must be at least 2");
   end
   if (STARTUP_CYC < 0) begin : g_bad_start
      $error("lpclk_ctrl: STARTUP_CYC must not be negative");
   end

   lp_mode_e           mode_w;
   logic [CNT_W-1:0]   cnt_w;
   logic               active_w, xclk_en_w, xgate_q;
   logic [NUM_SRC-1:0] want_w, busy_w, gclk_w, src_clk;

   lpclk_seq #(.STARTUP_CYC(STARTUP_CYC), .CNT_W(CNT_W)) u_seq (
      .clk      (clk_xtal),
      .rst_n    (rst_n),
      .wait_req (wait_req),
      .stop_req (stop_req),
      .wake     (wake),
      .reg_we   (reg_we),
      .wr_sel   (reg_sel_vco),
      .wr_pll   (reg_pll_on),
      .wr_keep  (reg_osc_keep),
      .mode_q   (mode_w),
      .cnt_q    (cnt_w),
      .sel_q    (sel_vco_o),
      .pll_q    (pll_on_o),
      .keep_q   (osc_keep_o),
      .osc_en   (osc_en),
      .pll_en   (pll_en),
      .active   (active_w),
      .xclk_en  (xclk_en_w),
      .want     (want_w)
   );

   assign src_clk[SRC_XTAL] = clk_xtal;
   assign src_clk[SRC_VCO]  = clk_vco;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      lpclk_branch #(.SYNC_STAGES(SYNC_STAGES)) u_br (
         .clk_src     (src_clk[g]),
         .rst_n       (rst_n),
         .want_a      (want_w[g]),
         .peer_busy_a (busy_w[NUM_SRC-1-g]),
         .clk_gated   (gclk_w[g]),
         .busy        (busy_w[g])
      );
   end

   // Crystal output gate changes only while the crystal is low.
   always_ff @(negedge clk_xtal or negedge rst_n) begin
      if (!rst_n) xgate_q <= 1'b1;
      else        xgate_q <= xclk_en_w;
   end

   assign xclk_out = clk_xtal & xgate_q;
   assign bus_clk  = |gclk_w;
   assign irq_out  = lock_irq_req & active_w;
endmodule

// File: rtl/lpclk_ctrl_chk.sv
`timescale 1ns/1ps
module lpclk_ctrl_chk
   import lpclk_pkg::*;
#(
   parameter int STARTUP_CYC = 16,
   parameter int CNT_W       = 5
) (
   input logic               clk_xtal,
   input logic               rst_n,
   input lp_mode_e           mode,
   input logic [CNT_W-1:0]   cnt,
   input logic               sel_o,
   input logic               pll_o,
   input logic               keep_o,
   input logic               osc_en,
   input logic               pll_en,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] gclk
);
   p_sel_needs_pll_r3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      sel_o |-> pll_o);

   p_cfg_frozen_r3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      (mode == M_STOP || mode == M_START) |=> ($stable(pll_o) && $stable(keep_o)));

   p_branch_excl_r4: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      $onehot0(gclk));

   p_wait_live_r5: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      (mode == M_WAIT) |-> (osc_en && (pll_en == pll_o)));

   p_stop_no_pll_r7: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      (mode == M_STOP) |-> (!pll_en && !irq_out));

   p_stop_sel_clr_r8: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      (mode == M_STOP) |-> !sel_o);

   p_startup_len_r9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      (mode == M_START) |-> (int'(cnt) < STARTUP_CYC));

   p_wake_path_r9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      (mode != M_STOP && $past(mode) == M_STOP && !keep_o && STARTUP_CYC > 0)
         |-> (mode == M_START));
endmodule

bind lpclk_ctrl lpclk_ctrl_chk #(.STARTUP_CYC(STARTUP_CYC), .CNT_W(CNT_W)) u_chk (
   .clk_xtal (clk_xtal),
   .rst_n    (rst_n),
   .mode     (mode_w),
   .cnt      (cnt_w),
   .sel_o    (sel_vco_o),
   .pll_o    (pll_on_o),
   .keep_o   (osc_keep_o),
   .osc_en   (osc_en),
   .pll_en   (pll_en),
   .irq_out  (irq_out),
   .gclk     (gclk_w)
);

// File: tb/lpclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpclk_ctrl_tb_top;
   localparam int STARTUP = 16;
   localparam int WIN_NS  = 960;

   logic clk_xtal = 1'b0, clk_vco = 1'b0, rst_n = 1'b0;
   logic wait_req = 1'b0, stop_req = 1'b0, wake = 1'b0;
   logic reg_we = 1'b0, reg_sel_vco = 1'b0, reg_pll_on = 1'b0, reg_osc_keep = 1'b0;
   logic lock_irq_req = 1'b0;
   logic osc_en, pll_en, irq_out, xclk_out, bus_clk, sel_vco_o, pll_on_o, osc_keep_o;

   int n_checks = 0, n_errors = 0;
   bit done = 1'b0;

   always #4 clk_xtal = ~clk_xtal;
   always #3 clk_vco  = ~clk_vco;

   lpclk_ctrl #(.STARTUP_CYC(STARTUP), .SYNC_STAGES(2)) dut_i (
      .clk_xtal(clk_xtal), .clk_vco(clk_vco), .rst_n(rst_n),
      .wait_req(wait_req), .stop_req(stop_req), .wake(wake),
      .reg_we(reg_we), .reg_sel_vco(reg_sel_vco), .reg_pll_on(reg_pll_on),
      .reg_osc_keep(reg_osc_keep), .lock_irq_req(lock_irq_req),
      .osc_en(osc_en), .pll_en(pll_en), .irq_out(irq_out), .xclk_out(xclk_out),
      .bus_clk(bus_clk), .sel_vco_o(sel_vco_o), .pll_on_o(pll_on_o),
      .osc_keep_o(osc_keep_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_near(input string tag, input int act, input int exp);
      n_checks++;
      if (act < exp - 1 || act > exp + 1) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d (+-1) at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: modes 0 run, 1 wait, 2 stop, 3 start-up.
   int m_mode = 0, m_n = 0;
   bit m_sel = 0, m_pll = 0, m_keep = 0;

   always @(negedge clk_xtal) begin
      if (rst_n && !done) begin
         int  nm;
         bit  acc, act;
         nm  = m_mode;
         acc = reg_we && (m_mode <= 1);
         case (m_mode)
            0: if (stop_req) nm = 2; else if (wait_req) nm = 1;
            1: if (wake) nm = 0;
            2: if (wake) begin
                  if (m_keep) nm = 0;
                  else begin nm = 3; m_n = STARTUP; end
               end
            default: begin m_n--; if (m_n == 0) nm = 0; end
         endcase
         if (acc) begin
            m_pll  = reg_pll_on;
            m_keep = reg_osc_keep;
            m_sel  = reg_sel_vco && reg_pll_on;
         end
         if (nm == 2 && m_mode != 2) m_sel = 0;
         m_mode = nm;
         act = (m_mode <= 1);
         check("R6/R9 osc_en", int'(osc_en), int'(!(m_mode == 2 && !m_keep)));
         check("R12/R7 pll_en", int'(pll_en), int'(m_pll && act));
         check("R10 irq_out", int'(irq_out), int'(lock_irq_req && act));
         check("R8/R3 sel readback", int'(sel_vco_o), int'(m_sel));
         check("R3 pll_on readback", int'(pll_on_o), int'(m_pll));
         check("R3 keep readback", int'(osc_keep_o), int'(m_keep));
      end
   end

   // Edge counters and phase-width monitor on bus_clk.
   int bus_rises = 0, x_rises = 0;
   realtime t_rise = 0.0, t_fall = 0.0;
   bit seen_r = 0, seen_f = 0;

   always @(posedge xclk_out) x_rises++;

   always @(posedge bus_clk) begin
      if (rst_n) begin
         if (seen_f && !done) begin
            n_checks++;
            if ($realtime - t_fall < 5.9) begin
               n_errors++;
               $display("FAIL R4 low phase: actual %0.2f expected >= 6.00", $realtime - t_fall);
            end
         end
         t_rise = $realtime; seen_r = 1;
         bus_rises++;
      end
   end

   always @(negedge bus_clk) begin
      if (rst_n) begin
         if (seen_r && !done) begin
            n_checks++;
            if ($realtime - t_rise < 5.9) begin
               n_errors++;
               $display("FAIL R4 high phase: actual %0.2f expected >= 6.00", $realtime - t_rise);
            end
         end
         t_fall = $realtime; seen_f = 1;
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk_xtal);
      #1;
   endtask

   task automatic measure(input string tag, input int win, input int exp_bus, input int exp_x);
      int b0, x0;
      b0 = bus_rises; x0 = x_rises;
      #(win);
      if (exp_bus == 0) check({tag, " bus edges"}, bus_rises - b0, 0);
      else              check_near({tag, " bus edges"}, bus_rises - b0, exp_bus);
      if (exp_x == 0)   check({tag, " xclk edges"}, x_rises - x0, 0);
      else              check_near({tag, " xclk edges"}, x_rises - x0, exp_x);
   endtask

   task automatic wr(input bit s, input bit p, input bit k);
      reg_we = 1; reg_sel_vco = s; reg_pll_on = p; reg_osc_keep = k;
      tick();
      reg_we = 0; reg_sel_vco = 0; reg_pll_on = 0; reg_osc_keep = 0;
   endtask

   task automatic pulse(input int which);
      case (which)
         0: stop_req = 1;
         1: wait_req = 1;
         2: wake = 1;
         default: begin stop_req = 1; wait_req = 1; end
      endcase
      tick();
      stop_req = 0; wait_req = 0; wake = 0;
   endtask

   initial begin : watchdog
      #2_000_000;
      if (!done) begin
         done = 1;
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : stim
      #20;
      @(negedge clk_xtal); #1;
      rst_n = 1;
      tick(2);
      // R1: reset state
      check("R1 sel after reset", int'(sel_vco_o), 0);
      check("R1 pll_on after reset", int'(pll_on_o), 0);
      check("R1 keep after reset", int'(osc_keep_o), 0);
      check("R1 osc_en after reset", int'(osc_en), 1);
      check("R1 pll_en after reset", int'(pll_en), 0);
      tick(10);
      measure("R1 R2 crystal/2 after reset", WIN_NS, WIN_NS / 16, WIN_NS / 8);

      // R3: select without PLL-on is dropped
      wr(1, 0, 0);
      check("R3 select ignored", int'(sel_vco_o), 0);
      tick(30);
      measure("R3 bus stays crystal/2", WIN_NS, WIN_NS / 16, WIN_NS / 8);

      // R2, R4: move to VCO/2
      wr(0, 1, 0);
      check("R12 pll_en follows bit", int'(pll_en), 1);
      wr(1, 1, 0);
      tick(30);
      measure("R2 R4 vco/2", WIN_NS, WIN_NS / 12, WIN_NS / 8);

      // R10: interrupt passes in run
      lock_irq_req = 1;
      tick(2);
      check("R10 irq in run", int'(irq_out), 1);

      // R5, R11: wait keeps clocks; stop ignored in wait
      pulse(1);
      tick(2);
      measure("R5 vco/2 in wait", WIN_NS, WIN_NS / 12, WIN_NS / 8);
      check("R5 pll_en in wait", int'(pll_en), 1);
      pulse(0);
      tick(3);
      check("R11 stop ignored in wait osc", int'(osc_en), 1);
      pulse(2);
      pulse(2); // R11 wake in run ignored
      tick(2);

      // R2, R4: back to crystal and again to VCO
      wr(0, 1, 0);
      tick(30);
      measure("R2 R4 back to crystal/2", WIN_NS, WIN_NS / 16, WIN_NS / 8);
      wr(1, 1, 0);
      tick(30);
      measure("R2 R4 vco/2 again", WIN_NS, WIN_NS / 12, WIN_NS / 8);

      // R6, R8: stop while on VCO, oscillator off
      pulse(0);
      check("R8 select cleared on stop", int'(sel_vco_o), 0);
      check("R6 osc_en in stop", int'(osc_en), 0);
      tick(10);
      measure("R6 quiet in stop", WIN_NS, 0, 0);
      wr(1, 1, 1); // R3 ignored in stop
      tick(2);

      // R9: start-up wait after wake
      pulse(2);
      check("R9 osc_en in start-up", int'(osc_en), 1);
      measure("R9 quiet in start-up", 80, 0, 0);
      tick(20);
      check("R9 pll_en back after start-up", int'(pll_en), 1);
      tick(30);
      measure("R8 crystal/2 after wake", WIN_NS, WIN_NS / 16, WIN_NS / 8);

      // R7: oscillator kept in stop; R9 immediate wake
      wr(1, 1, 1);
      tick(30);
      pulse(3); // R11 stop beats wait
      check("R7 osc_en kept", int'(osc_en), 1);
      check("R7 pll_en off", int'(pll_en), 0);
      tick(10);
      measure("R7 xclk runs, bus quiet", WIN_NS, 0, WIN_NS / 8);
      pulse(2);
      check("R9 immediate run pll_en", int'(pll_en), 1);
      check("R8 select still clear", int'(sel_vco_o), 0);
      tick(30);
      measure("R8 crystal/2 after kept stop", WIN_NS, WIN_NS / 16, WIN_NS / 8);

      lock_irq_req = 0;
      tick(4);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule